// File: doc/BRIEF.md
# Hot-Plug Slot Command Processor

This block takes 16-bit command words for a hot-plug controller and carries them out against a small bank of slots. Each slot holds three 2-bit items: its power/enable state, its power indicator and its attention indicator. One command word names a target slot and an op code. In a slot operation, the op code's bit-fields can change all three items in one action. Other code ranges set the bus speed/mode of the whole segment, or move every slot to power-only or to enabled together. Codes that are not defined are rejected with an error flag.

Commands arrive on a valid/ready port. `cmd_ready` equals the inverse of `busy`. A word is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. When a word is offered while the block is busy, the block does not take it and does not store it. The sender may keep `cmd_valid` high and offer the word again after `busy` clears. Every taken command runs for exactly `EXEC_CYCLES` cycles. Its effects then appear together with the fall of `busy` and a one-cycle `cmd_done` pulse, which feeds the interrupt logic. The retention-latch inputs are sampled in that final cycle.

Top module: `hp_cmd_engine`

## Requirements
- R1: The command word carries the op code in bits 7:0 and the target slot in bits 15:8. An op code from 00h to 3Fh is a slot operation. In a slot operation, bits 1:0 set the slot state (1 power-only, 2 enabled, 3 disabled), bits 3:2 set the power indicator and bits 5:4 set the attention indicator (each 1 on, 2 blink, 3 off). Slot i's items appear in bits 2i+1:2i of `slot_state`, `pwr_ind` and `attn_ind`.
- R2: A field value of 0 in a slot operation leaves that item unchanged.
- R3: A slot operation whose state field is 1 or 2 goes to the switch-open error when the target slot's `latch_open` bit is 1. That slot is then left entirely unchanged. A disable command, or one that only changes indicators, is still carried out when the latch is open.
- R4: The invalid-command error is raised, and nothing changes, in two cases. The first is a slot operation whose target is at or above NUM_SLOTS. The second is any code in 4Ah–4Fh or 60h–FFh.
- R5: Codes 40h–44h load `seg_speed` with the code's low nibble (0 to 4). Codes 45h–47h raise the invalid-speed error and leave `seg_speed` unchanged.
- R6: Codes 50h–5Dh load `seg_speed` with the low nibble, but only when PROG_REV is 2. Otherwise they raise the invalid-speed error. Codes 5Eh and 5Fh always raise the invalid-speed error.
- R7: Code 48h sets every slot's state to 1 and code 49h sets every slot's state to 2. If any `latch_open` bit is 1, either code raises the switch-open error and no slot changes. The target field is ignored for these codes and for speed codes.
- R8: `busy` rises in the cycle after a command is taken. It stays high for exactly EXEC_CYCLES cycles, and `cmd_ready` is low for that whole time.
- R9: A word offered while `busy` is high is not taken and has no effect on any output.
- R10: `cmd_done` pulses high for exactly one cycle. The pulse is in the cycle in which `busy` has just cleared and the command's effects first appear.
- R11: The error flags `err_switch_open`, `err_invalid_cmd` and `err_invalid_speed` all clear when a command is taken. At most one of them is then set on completion, and it holds until the next command is taken.
- R12: After reset every slot's state and indicators are 3, `seg_speed` is 0, and `busy`, `cmd_done` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block can take a command (not busy) |
| cmd_word | input | 16 | Target slot [15:8], op code [7:0] |
| latch_open | input | NUM_SLOTS | Per-slot retention latch open |
| busy | output | 1 | Command in execution |
| err_switch_open | output | 1 | Last command refused due to open latch |
| err_invalid_cmd | output | 1 | Last command reserved or bad slot |
| err_invalid_speed | output | 1 | Last command gave an unsupported speed/mode |
| cmd_done | output | 1 | One-cycle completion event |
| slot_state | output | 2*NUM_SLOTS | Per-slot state code |
| pwr_ind | output | 2*NUM_SLOTS | Per-slot power indicator code |
| attn_ind | output | 2*NUM_SLOTS | Per-slot attention indicator code |
| seg_speed | output | 4 | Segment speed/mode code |

## Verification
Some rules are checked by the assertions on every cycle. The completion pulse lasts one cycle and coincides with the fall of busy. Busy stays up while the countdown runs. The error flags clear when a command is taken and hold while the block is idle, and at most one is set at a time. A switch-open refusal leaves the slot states untouched, and a slot's items hold when nothing writes them. Other behaviour needs the bench's scenarios to show it, because each case depends on the value decoded from a particular op code: the field encodings, the zero-means-keep rule, each reserved range and its error, the speed codes under both interface revisions, and the all-slot commands with an open latch. The bench also shows that a word offered during busy leaves no trace.

// File: rtl/hp_cmd_pkg.sv
package hp_cmd_pkg;
  localparam int CMD_W = 16;
  localparam logic [1:0] ST_PWR_ONLY = 2'd1;
  localparam logic [1:0] ST_ENABLED  = 2'd2;
  localparam logic [1:0] ST_DISABLED = 2'd3;
  localparam logic [1:0] IND_OFF     = 2'd3;
  localparam logic [7:0] OP_ALL_PWR  = 8'h48;
  localparam logic [7:0] OP_ALL_EN   = 8'h49;

  typedef struct packed {
    logic       err_sw;
    logic       err_cmd;
    logic       err_spd;
    logic       slot_we;
    logic [7:0] target;
    logic [1:0] st_f;
    logic [1:0] pi_f;
    logic [1:0] ai_f;
    logic       all_we;
    logic [1:0] all_st;
    logic       spd_we;
    logic [3:0] spd_val;
  } hp_action_t;
endpackage

// File: rtl/hp_cmd_seq.sv
module hp_cmd_seq #(
  parameter int CW          = 16,
  parameter int EXEC_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [CW-1:0] cmd_in,
  output logic          ready,
  output logic          accept,
  output logic          apply,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cmd_held
);
  localparam int CNT_W = $clog2(EXEC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(EXEC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign ready  = !busy;
  assign accept = cmd_valid && !busy;
  assign apply  = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      cmd_held <= '0;
      done     <= 1'b0;
    end else begin
      done <= apply;
      if (accept) begin
        busy     <= 1'b1;
        cnt_q    <= CNT_INIT;
        cmd_held <= cmd_in;
      end else if (apply) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> busy);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/hp_cmd_decode.sv
module hp_cmd_decode
  import hp_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PROG_REV  = 2
) (
  input  logic [CMD_W-1:0]     cmd,
  input  logic [NUM_SLOTS-1:0] latch_open,
  output hp_action_t           act
);
  logic [7:0] op, tgt;
  logic is_slot, is_a, is_b, is_allp, is_alle, tgt_ok, latch_sel, pwr_req, a_ok, b_ok, any_latch;

  assign op  = cmd[7:0];
  assign tgt = cmd[15:8];

  always_comb begin
    latch_sel = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (int'(tgt) == i) latch_sel = latch_open[i];
  end

  assign is_slot   = (op[7:6] == 2'b00);
  assign is_a      = (op[7:3] == 5'b01000);
  assign is_b      = (op[7:4] == 4'h5);
  assign is_allp   = (op == OP_ALL_PWR);
  assign is_alle   = (op == OP_ALL_EN);
  assign tgt_ok    = (int'(tgt) < NUM_SLOTS);
  assign pwr_req   = (op[1:0] == ST_PWR_ONLY) || (op[1:0] == ST_ENABLED);
  assign a_ok      = (op[2:0] <= 3'd4);
  assign b_ok      = (PROG_REV == 2) && (op[3:0] <= 4'hD);
  assign any_latch = |latch_open;

  always_comb begin
    act         = '0;
    act.target  = tgt;
    act.st_f    = op[1:0];
    act.pi_f    = op[3:2];
    act.ai_f    = op[5:4];
    act.spd_val = op[3:0];
    act.all_st  = is_allp ? ST_PWR_ONLY : ST_ENABLED;
    act.err_cmd = (is_slot && !tgt_ok) || !(is_slot || is_a || is_b || is_allp || is_alle);
    act.err_spd = (is_a && !a_ok) || (is_b && !b_ok);
    act.err_sw  = (is_slot && tgt_ok && pwr_req && latch_sel) ||
                  ((is_allp || is_alle) && any_latch);
    act.slot_we = is_slot && tgt_ok && !act.err_sw;
    act.all_we  = (is_allp || is_alle) && !any_latch;
    act.spd_we  = (is_a && a_ok) || (is_b && b_ok);
  end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] st_f,
  input  logic [1:0] pi_f,
  input  logic [1:0] ai_f,
  input  logic       all_en,
  input  logic [1:0] all_st,
  output logic [1:0] st,
  output logic [1:0] pi,
  output logic [1:0] ai
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_DISABLED;
      pi <= IND_OFF;
      ai <= IND_OFF;
    end else if (all_en) begin
      st <= all_st;
    end else if (wr_en) begin
      if (st_f != 2'd0) st <= st_f;
      if (pi_f != 2'd0) pi <= pi_f;
      if (ai_f != 2'd0) ai <= ai_f;
    end
  end

  assert_slot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !all_en) |=> ($stable(st) && $stable(pi) && $stable(ai)));
endmodule

// File: rtl/hp_cmd_engine.sv
module hp_cmd_engine
  import hp_cmd_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int EXEC_CYCLES = 4,
  parameter int PROG_REV    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [15:0]            cmd_word,
  input  logic [NUM_SLOTS-1:0]   latch_open,
  output logic                   busy,
  output logic                   err_switch_open,
  output logic                   err_invalid_cmd,
  output logic                   err_invalid_speed,
  output logic                   cmd_done,
  output logic [2*NUM_SLOTS-1:0] slot_state,
  output logic [2*NUM_SLOTS-1:0] pwr_ind,
  output logic [2*NUM_SLOTS-1:0] attn_ind,
  output logic [3:0]             seg_speed
);
  logic             accept, apply;
  logic [CMD_W-1:0] cmd_held;
  hp_action_t       act;

  hp_cmd_seq #(.CW(CMD_W), .EXEC_CYCLES(EXEC_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_in(cmd_word),
    .ready(cmd_ready), .accept(accept), .apply(apply), .busy(busy),
    .done(cmd_done), .cmd_held(cmd_held)
  );

  hp_cmd_decode #(.NUM_SLOTS(NUM_SLOTS), .PROG_REV(PROG_REV)) u_dec (
    .cmd(cmd_held), .latch_open(latch_open), .act(act)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = apply && act.slot_we && (int'(act.target) == g);
    hp_slot_regs u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(hit),
      .st_f(act.st_f), .pi_f(act.pi_f), .ai_f(act.ai_f),
      .all_en(apply && act.all_we), .all_st(act.all_st),
      .st(slot_state[2*g +: 2]), .pi(pwr_ind[2*g +: 2]), .ai(attn_ind[2*g +: 2])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_switch_open   <= 1'b0;
      err_invalid_cmd   <= 1'b0;
      err_invalid_speed <= 1'b0;
      seg_speed         <= 4'd0;
    end else if (accept) begin
      err_switch_open   <= 1'b0;
      err_invalid_cmd   <= 1'b0;
      err_invalid_speed <= 1'b0;
    end else if (apply) begin
      err_switch_open   <= act.err_sw;
      err_invalid_cmd   <= act.err_cmd;
      err_invalid_speed <= act.err_spd;
      if (act.spd_we) seg_speed <= act.spd_val;
    end
  end

  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !(err_switch_open || err_invalid_cmd || err_invalid_speed));
  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> ($stable(err_switch_open) && $stable(err_invalid_cmd) && $stable(err_invalid_speed)));
  assert_err_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_switch_open, err_invalid_cmd, err_invalid_speed}));
  assert_refused_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && err_switch_open) |-> $stable(slot_state));
endmodule

// File: tb/hp_cmd_engine_test.sv
module hp_cmd_engine_test;
  localparam int N = 4;
  localparam int E = 4;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [15:0] cmd_word = 0;
  logic [N-1:0] latch_open = 0;
  logic cmd_ready, busy, e_sw, e_cmd, e_spd, cmd_done;
  logic [2*N-1:0] st, pi, ai;
  logic [3:0] spd;
  logic r1_rdy, r1_busy, r1_sw, r1_cmd, r1_spd, r1_done;
  logic [2*N-1:0] r1_st, r1_pi, r1_ai;
  logic [3:0] r1_speed;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hp_cmd_engine #(.NUM_SLOTS(N), .EXEC_CYCLES(E), .PROG_REV(2)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .latch_open(latch_open), .busy(busy),
    .err_switch_open(e_sw), .err_invalid_cmd(e_cmd), .err_invalid_speed(e_spd),
    .cmd_done(cmd_done), .slot_state(st), .pwr_ind(pi), .attn_ind(ai), .seg_speed(spd));

  hp_cmd_engine #(.NUM_SLOTS(N), .EXEC_CYCLES(E), .PROG_REV(1)) uut_rev1 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(r1_rdy),
    .cmd_word(cmd_word), .latch_open(latch_open), .busy(r1_busy),
    .err_switch_open(r1_sw), .err_invalid_cmd(r1_cmd), .err_invalid_speed(r1_spd),
    .cmd_done(r1_done), .slot_state(r1_st), .pwr_ind(r1_pi), .attn_ind(r1_ai), .seg_speed(r1_speed));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends one word, checks busy timing (R8), done pulse (R10) and error flags
  task automatic send(input logic [15:0] w, input logic [2:0] exp_err, input string req);
    @(negedge clk);
    cmd_word = w; cmd_valid = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    check("R8 busy after accept", {busy, cmd_ready}, 2'b10);
    repeat (E - 1) @(posedge clk);
    @(negedge clk);
    check("R8 busy through last cycle", {busy, cmd_done}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    check("R10 done with busy fall", {busy, cmd_done}, 2'b01);
    check(req, {e_spd, e_cmd, e_sw}, exp_err);
  endtask

  task automatic t_reset();
    check("R12 state", st, 8'hFF);
    check("R12 pwr ind", pi, 8'hFF);
    check("R12 attn ind", ai, 8'hFF);
    check("R12 speed", spd, 0);
    check("R12 flags", {busy, cmd_done, e_sw, e_cmd, e_spd, cmd_ready}, 6'b000001);
  endtask

  task automatic t_slot_op();
    send(16'h013A, 3'b000, "R1 slot op errors");
    check("R1 state", st, 8'hFB);
    check("R1 pwr ind", pi, 8'hFB);
    check("R1 attn ind", ai, 8'hFF);
    @(negedge clk);
    check("R10 done one cycle", cmd_done, 0);
  endtask

  task automatic t_zero_keep();
    send(16'h0110, 3'b000, "R2 errors");
    check("R2 attn set", ai, 8'hF7);
    check("R2 state kept", st, 8'hFB);
    check("R2 pwr kept", pi, 8'hFB);
  endtask

  task automatic t_latch();
    latch_open = 4'b0100;
    send(16'h0205, 3'b001, "R3 switch open");
    check("R3 state kept", st, 8'hFB);
    check("R3 pwr kept", pi, 8'hFB);
    repeat (2) @(negedge clk);
    check("R11 error held", e_sw, 1);
    latch_open = 4'b0001;
    send(16'h0023, 3'b000, "R3 disable allowed, R11 cleared");
    check("R3 attn on open slot", ai, 8'hF6);
    latch_open = 0;
  endtask

  task automatic t_invalid();
    send(16'h0402, 3'b010, "R4 slot out of range");
    send(16'h0060, 3'b010, "R4 reserved 60h");
    send(16'h00C5, 3'b010, "R4 reserved C5h");
    send(16'h004C, 3'b010, "R4 reserved 4Ch");
    check("R4 state kept", st, 8'hFB);
    check("R4 attn kept", ai, 8'hF6);
  endtask

  task automatic t_speed_a();
    send(16'h0743, 3'b000, "R5 code 43h");
    check("R5 speed", spd, 3);
    send(16'h0046, 3'b100, "R5 code 46h");
    check("R5 speed kept", spd, 3);
  endtask

  task automatic t_speed_b();
    send(16'h005B, 3'b000, "R6 code 5Bh");
    check("R6 speed rev2", spd, 4'hB);
    check("R6 rev1 error", r1_spd, 1);
    check("R6 rev1 speed kept", r1_speed, 3);
    send(16'h005F, 3'b100, "R6 code 5Fh");
    check("R6 speed kept", spd, 4'hB);
  endtask

  task automatic t_all();
    latch_open = 4'b1000;
    send(16'h0048, 3'b001, "R7 all with latch open");
    check("R7 state kept", st, 8'hFB);
    latch_open = 0;
    send(16'h0948, 3'b000, "R7 all power-only");
    check("R7 all power-only", st, 8'h55);
    send(16'h0049, 3'b000, "R7 all enabled");
    check("R7 all enabled", st, 8'hAA);
    check("R7 indicators kept", {pi, ai}, 16'hFBF6);
  endtask

  task automatic t_busy_write();
    @(negedge clk);
    cmd_word = 16'h0031; cmd_valid = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_word = 16'h0103;
    check("R9 not ready while busy", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 0;
    repeat (E + 2) @(negedge clk);
    check("R9 first applied", st, 8'hA9);
    check("R9 second ignored", ai, 8'hF7);
    check("R9 idle", {busy, cmd_done}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_slot_op();
    t_zero_keep();
    t_latch();
    t_invalid();
    t_speed_a();
    t_speed_b();
    t_all();
    t_busy_write();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule